// File: doc/BRIEF.md
# PCIe TLP Trace Selection Filter

This block sits beside the transaction-layer datapath of a PCIe core and decides, for every TLP header that passes, whether that header is handed to the trace capture logic. Each TLP arrives as a one-cycle descriptor. The descriptor gives the direction (inbound or outbound) and the TLP class (posted, non-posted or completion). It also carries a flag that marks an inbound completion as belonging to the remote-to-local DMA or peer-to-peer group, plus the 16-bit requester ID and the index of the core port the TLP crossed.

Static configuration selects the match mode through a 20-bit filter word. In one mode the filter matches a single requester ID exactly. In the other it holds a mask of core ports, and any number of ports may be set. The configuration also holds an 8-bit class mask, a 4-bit direction code and a 4-bit record-format code. The meaning of the direction code changes with the format. The compact record format allows mixed inbound/outbound tracing. The wide record format selects exactly one traffic group.

The block drives a registered, single-cycle capture strobe one clock after each accepted descriptor. It also drives a registered configuration-error flag. While the error flag is raised, nothing is captured.

Top module: `trace_tlp_selector`

## Requirements
- R1: With filter bit 19 = 0 (requester mode), a TLP is eligible only when its 16-bit requester ID equals filter bits 15:0 exactly.
- R2: With filter bit 19 = 1 (port mode), a TLP is eligible when filter bit `tlp_port` (within 15:0) is set, and several port bits may be set together. A port index is derived from a slot number as (slot & 7) * 2, so slot 0x10 gives index 0 and slot 0x11 gives index 2.
- R3: Filter bits 18:16 have no effect on matching.
- R4: Class encoding on `tlp_class` is 0 = posted, 1 = non-posted, 2 = completion, 3 = invalid. A TLP is eligible only when `cfg_type` bit [class] is set, and class 3 is never captured. `cfg_type` bits 7:3 are ignored.
- R5: With `cfg_fmt` = 0 (compact format), `cfg_dir` selects traffic as follows. Code 1 selects outbound traffic of all classes. Code 0 selects all inbound traffic. Code 2 selects outbound traffic together with inbound posted, non-posted and group-B completions. Code 3 selects outbound traffic together with inbound group-A completions.
- R6: With `cfg_fmt` = 1 (wide format), `cfg_dir` selects traffic as follows. Code 2 selects inbound posted, non-posted and group-B completions. Code 3 selects inbound group-A completions only. Code 1 selects outbound traffic of all classes.
- R7: An inbound completion with `tlp_cpl_remote` = 1 is group B (remote-to-local DMA or peer-to-peer). With `tlp_cpl_remote` = 0 it is group A.
- R8: When the decoded direction selects outbound traffic and `cfg_type` bits 2:0 do not hold exactly one set bit, `cfg_err` is 1 and no TLP is captured.
- R9: A format code above 1, a direction code above 3, or direction code 0 with the wide format sets `cfg_err` to 1 and suppresses every capture.
- R10: `capture` is a one-cycle pulse in the cycle after a valid, eligible descriptor. It is never 1 without a valid descriptor in the previous cycle, and never 1 when `trace_en` was 0 in that cycle. `cfg_err` reflects the configuration present one cycle earlier.
- R11: While `rst_n` is low, `capture` and `cfg_err` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| trace_en | input | 1 | Tracing enabled |
| cfg_filter | input | 20 | Filter word: bit 19 selects the mode, bits 15:0 hold the ID or port mask |
| cfg_type | input | 8 | Class mask (bit 0 posted, bit 1 non-posted, bit 2 completion) |
| cfg_dir | input | 4 | Direction code |
| cfg_fmt | input | 4 | Record format code (0 compact, 1 wide) |
| tlp_valid | input | 1 | Descriptor valid this cycle |
| tlp_outbound | input | 1 | 1 = outbound TLP, 0 = inbound TLP |
| tlp_class | input | 2 | TLP class code |
| tlp_cpl_remote | input | 1 | Inbound completion is group B |
| tlp_req_id | input | 16 | Requester ID |
| tlp_port | input | 4 | Core port index |
| capture | output | 1 | Registered capture strobe |
| cfg_err | output | 1 | Registered configuration-error flag |

## Verification
Requester mode is tried with an exact ID, with IDs that differ by one, and with the reserved filter bits set. These cases separate an exact compare from a partial or reserved-bit-sensitive one. Port mode uses a two-port mask built from slot numbers, hitting the set ports and a clear port between them. A full sweep of format, direction code, direction, class and completion group separates the two format tables and the A/B completion split. Further cases cover multi-bit and empty class masks with outbound selected, the reserved codes, tracing disabled, and back-to-back valid descriptors. These check error gating and the one-cycle strobe.

// File: rtl/tts_pkg.sv
package tts_pkg;
   typedef enum logic [1:0] {
      TLP_POSTED = 2'd0,
      TLP_NONPOST = 2'd1,
      TLP_CPL = 2'd2,
      TLP_INVALID = 2'd3
   } tlp_class_e;

   typedef struct packed {
      logic out_en;
      logic in_pn;
      logic in_cpl_a;
      logic in_cpl_b;
   } dir_sel_t;

   localparam int unsigned FMT_COMPACT = 0;
   localparam int unsigned FMT_WIDE = 1;
endpackage

// File: rtl/tts_filter_match.sv
module tts_filter_match #(
   parameter int unsigned ID_W = 16,
   parameter int unsigned PORTS = 16,
   localparam int unsigned FILT_W = ID_W + 4,
   localparam int unsigned PIDX_W = $clog2(PORTS)
) (
   input  logic [FILT_W-1:0] filter_word,
   input  logic [ID_W-1:0]   req_id,
   input  logic [PIDX_W-1:0] port_idx,
   output logic              hit
);
   logic [PORTS-1:0] port_hit;
   logic             id_hit;
   logic             unused_rsvd;

   assign unused_rsvd = ^filter_word[FILT_W-2:ID_W];

   for (genvar p = 0; p < PORTS; p++) begin : g_port
      assign port_hit[p] = filter_word[p] && (port_idx == PIDX_W'(p));
   end

   assign id_hit = (req_id == filter_word[ID_W-1:0]);
   assign hit = filter_word[FILT_W-1] ? (|port_hit) : id_hit;
endmodule

// File: rtl/tts_dir_decode.sv
module tts_dir_decode
   import tts_pkg::*;
#(
   parameter int unsigned DIR_W = 4,
   parameter int unsigned FMT_W = 4,
   parameter int unsigned TYPE_W = 8
) (
   input  logic [DIR_W-1:0]  dir_code,
   input  logic [FMT_W-1:0]  fmt_code,
   input  logic [TYPE_W-1:0] type_mask,
   output dir_sel_t          sel,
   output logic              bad
);
   logic code_bad;
   logic unused_type;

   assign unused_type = ^type_mask[TYPE_W-1:3];

   always_comb begin
      sel = '0;
      code_bad = 1'b0;
      if (fmt_code > FMT_W'(FMT_WIDE) || dir_code > DIR_W'(3)) begin
         code_bad = 1'b1;
      end else if (fmt_code == FMT_W'(FMT_COMPACT)) begin
         case (dir_code[1:0])
            2'd0: begin sel.in_pn = 1'b1; sel.in_cpl_a = 1'b1; sel.in_cpl_b = 1'b1; end
            2'd1: sel.out_en = 1'b1;
            2'd2: begin sel.out_en = 1'b1; sel.in_pn = 1'b1; sel.in_cpl_b = 1'b1; end
            default: begin sel.out_en = 1'b1; sel.in_cpl_a = 1'b1; end
         endcase
      end else begin
         case (dir_code[1:0])
            2'd0: code_bad = 1'b1;
            2'd1: sel.out_en = 1'b1;
            2'd2: begin sel.in_pn = 1'b1; sel.in_cpl_b = 1'b1; end
            default: sel.in_cpl_a = 1'b1;
         endcase
      end
   end

   assign bad = code_bad || (sel.out_en && ($countones(type_mask[2:0]) != 1));
endmodule

// File: rtl/trace_tlp_selector.sv
module trace_tlp_selector
   import tts_pkg::*;
#(
   parameter int unsigned ID_W = 16,
   parameter int unsigned PORTS = 16,
   parameter int unsigned TYPE_W = 8,
   parameter int unsigned DIR_W = 4,
   parameter int unsigned FMT_W = 4,
   localparam int unsigned FILT_W = ID_W + 4,
   localparam int unsigned PIDX_W = $clog2(PORTS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              trace_en,
   input  logic [FILT_W-1:0] cfg_filter,
   input  logic [TYPE_W-1:0] cfg_type,
   input  logic [DIR_W-1:0]  cfg_dir,
   input  logic [FMT_W-1:0]  cfg_fmt,
   input  logic              tlp_valid,
   input  logic              tlp_outbound,
   input  logic [1:0]        tlp_class,
   input  logic              tlp_cpl_remote,
   input  logic [ID_W-1:0]   tlp_req_id,
   input  logic [PIDX_W-1:0] tlp_port,
   output logic              capture,
   output logic              cfg_err
);
   if (PORTS > ID_W || PORTS < 2) begin : g_bad_ports
      $error("PORTS must lie between 2 and ID_W");
   end
   if (TYPE_W < 4 || DIR_W < 2 || FMT_W < 2) begin : g_bad_widths
      $error("TYPE_W must be at least 4, DIR_W and FMT_W at least 2");
   end

   logic     filt_hit;
   logic     dir_bad;
   dir_sel_t dsel;
   logic     class_hit;
   logic     dir_hit;
   logic     cap_d;

   tts_filter_match #(.ID_W(ID_W), .PORTS(PORTS)) u_filt (
      .filter_word(cfg_filter),
      .req_id     (tlp_req_id),
      .port_idx   (tlp_port),
      .hit        (filt_hit)
   );

   tts_dir_decode #(.DIR_W(DIR_W), .FMT_W(FMT_W), .TYPE_W(TYPE_W)) u_dir (
      .dir_code (cfg_dir),
      .fmt_code (cfg_fmt),
      .type_mask(cfg_type),
      .sel      (dsel),
      .bad      (dir_bad)
   );

   always_comb begin
      class_hit = 1'b0;
      dir_hit = 1'b0;
      case (tlp_class_e'(tlp_class))
         TLP_POSTED:  class_hit = cfg_type[0];
         TLP_NONPOST: class_hit = cfg_type[1];
         TLP_CPL:     class_hit = cfg_type[2];
         default:     class_hit = 1'b0;
      endcase
      if (tlp_outbound)
         dir_hit = dsel.out_en;
      else if (tlp_class == TLP_CPL)
         dir_hit = tlp_cpl_remote ? dsel.in_cpl_b : dsel.in_cpl_a;
      else
         dir_hit = dsel.in_pn;
   end

   assign cap_d = trace_en && tlp_valid && !dir_bad && filt_hit && class_hit && dir_hit;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         capture <= 1'b0;
         cfg_err <= 1'b0;
      end else begin
         capture <= cap_d;
         cfg_err <= dir_bad;
      end
   end
endmodule

// File: rtl/tts_checker.sv
module tts_checker #(
   parameter int unsigned ID_W = 16,
   parameter int unsigned PORTS = 16,
   parameter int unsigned TYPE_W = 8,
   parameter int unsigned DIR_W = 4,
   parameter int unsigned FMT_W = 4,
   localparam int unsigned FILT_W = ID_W + 4,
   localparam int unsigned PIDX_W = $clog2(PORTS)
) (
   input logic              clk,
   input logic              rst_n,
   input logic              trace_en,
   input logic [FILT_W-1:0] cfg_filter,
   input logic [TYPE_W-1:0] cfg_type,
   input logic [DIR_W-1:0]  cfg_dir,
   input logic [FMT_W-1:0]  cfg_fmt,
   input logic              tlp_valid,
   input logic [1:0]        tlp_class,
   input logic [ID_W-1:0]   tlp_req_id,
   input logic [PIDX_W-1:0] tlp_port,
   input logic              capture,
   input logic              cfg_err
);
   logic armed;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) armed <= 1'b0;
      else        armed <= 1'b1;
   end

   p_req_exact_r1: assert property (@(posedge clk) disable iff (!rst_n)
      armed && capture && !$past(cfg_filter[FILT_W-1])
      |-> $past(tlp_req_id) == $past(cfg_filter[ID_W-1:0]));

   p_port_mask_r2: assert property (@(posedge clk) disable iff (!rst_n)
      armed && capture && $past(cfg_filter[FILT_W-1]) |-> $past(cfg_filter[tlp_port]));

   p_class_sel_r4: assert property (@(posedge clk) disable iff (!rst_n)
      armed && capture |-> $past(tlp_class != 2'd3 && cfg_type[tlp_class]));

   p_err_blocks_r8: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_err |-> !capture);

   p_rsvd_code_r9: assert property (@(posedge clk) disable iff (!rst_n)
      armed && $past(cfg_dir > DIR_W'(3) || cfg_fmt > FMT_W'(1)) |-> cfg_err && !capture);

   p_strobe_src_r10: assert property (@(posedge clk) disable iff (!rst_n)
      armed && capture |-> $past(trace_en && tlp_valid));

   always_comb begin
      if (!rst_n) begin
         a_reset_quiet_r11: assert (!capture && !cfg_err);
      end
   end
endmodule

bind trace_tlp_selector tts_checker #(
   .ID_W(ID_W), .PORTS(PORTS), .TYPE_W(TYPE_W), .DIR_W(DIR_W), .FMT_W(FMT_W)
) u_chk (
   .clk(clk), .rst_n(rst_n), .trace_en(trace_en), .cfg_filter(cfg_filter),
   .cfg_type(cfg_type), .cfg_dir(cfg_dir), .cfg_fmt(cfg_fmt),
   .tlp_valid(tlp_valid), .tlp_class(tlp_class), .tlp_req_id(tlp_req_id),
   .tlp_port(tlp_port), .capture(capture), .cfg_err(cfg_err)
);

// File: tb/tb_trace_tlp_selector.sv
module tb_trace_tlp_selector;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        trace_en = 1'b0;
   logic [19:0] cfg_filter = '0;
   logic [7:0]  cfg_type = 8'h01;
   logic [3:0]  cfg_dir = '0;
   logic [3:0]  cfg_fmt = '0;
   logic        tlp_valid = 1'b0;
   logic        tlp_outbound = 1'b0;
   logic [1:0]  tlp_class = '0;
   logic        tlp_cpl_remote = 1'b0;
   logic [15:0] tlp_req_id = '0;
   logic [3:0]  tlp_port = '0;
   logic        capture;
   logic        cfg_err;

   logic [19:0] p_filter = '0;
   logic [7:0]  p_type = 8'h01;
   logic [3:0]  p_dir = '0;
   logic [3:0]  p_fmt = '0;

   int checks = 0;
   int fails = 0;
   bit done = 1'b0;
   string       tag_q[$];
   logic [1:0]  exp_q[$];

   always #2 clk = ~clk;

   trace_tlp_selector dut (.*);

   function automatic int slot2port(int slot);
      return (slot & 7) * 2;
   endfunction

   // Expected {capture, cfg_err} derived from the requirement tables.
   function automatic logic [1:0] model(logic [19:0] f, logic [7:0] ty, logic [3:0] d,
                                        logic [3:0] fm, logic en, logic v, logic ob,
                                        logic [1:0] cl, logic rem, logic [15:0] rid,
                                        logic [3:0] pt);
      logic out_ok, pn_ok, ca_ok, cb_ok, err, fhit, thit, dhit;
      out_ok = 0; pn_ok = 0; ca_ok = 0; cb_ok = 0; err = 0;
      if (fm > 4'd1 || d > 4'd3) err = 1;                     // R9
      else if (fm == 4'd0) begin                               // R5
         out_ok = (d != 0);
         pn_ok  = (d == 0) || (d == 2);
         cb_ok  = (d == 0) || (d == 2);
         ca_ok  = (d == 0) || (d == 3);
      end else begin                                           // R6
         if (d == 0) err = 1;
         out_ok = (d == 1);
         pn_ok  = (d == 2);
         cb_ok  = (d == 2);
         ca_ok  = (d == 3);
      end
      if (!err && out_ok && $countones(ty[2:0]) != 1) err = 1; // R8
      fhit = f[19] ? f[pt] : (rid == f[15:0]);                 // R1 R2 R3
      thit = (cl != 2'd3) && ty[cl];                           // R4
      if (ob) dhit = out_ok;
      else if (cl == 2'd2) dhit = rem ? cb_ok : ca_ok;         // R7
      else dhit = pn_ok;
      return {en && v && !err && fhit && thit && dhit, err};
   endfunction

   task automatic set_cfg(logic [19:0] f, logic [7:0] ty, logic [3:0] d, logic [3:0] fm);
      p_filter = f; p_type = ty; p_dir = d; p_fmt = fm;
   endtask

   task automatic drive(string tag, logic en, logic v, logic ob, logic [1:0] cl,
                        logic rem, logic [15:0] rid, logic [3:0] pt);
      @(negedge clk);
      cfg_filter = p_filter; cfg_type = p_type; cfg_dir = p_dir; cfg_fmt = p_fmt;
      trace_en = en; tlp_valid = v; tlp_outbound = ob; tlp_class = cl;
      tlp_cpl_remote = rem; tlp_req_id = rid; tlp_port = pt;
      tag_q.push_back(tag);
      exp_q.push_back(model(p_filter, p_type, p_dir, p_fmt, en, v, ob, cl, rem, rid, pt));
   endtask

   // Monitor: outputs settle after the edge that registers the descriptor.
   initial begin
      forever begin
         @(posedge clk);
         #1;
         if (exp_q.size() > 0) begin
            string t;
            logic [1:0] e;
            t = tag_q.pop_front();
            e = exp_q.pop_front();
            checks++;
            if ({capture, cfg_err} !== e) begin
               fails++;
               $display("FAIL %s: capture/cfg_err = %b%b expected %b%b", t, capture, cfg_err, e[1], e[0]);
            end
         end
      end
   end

   initial begin
      int cyc = 0;
      while (!done && cyc < 20000) begin
         @(posedge clk);
         cyc++;
      end
      if (!done) begin
         fails++;
         checks++;
         $display("FAIL watchdog: run did not finish");
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      checks++;
      if (capture !== 1'b0 || cfg_err !== 1'b0) begin
         fails++;
         $display("FAIL R11: reset capture/cfg_err = %b%b expected 00", capture, cfg_err);
      end
      rst_n = 1'b1;

      // R1 exact requester match
      set_cfg(20'h00101, 8'h01, 4'd0, 4'd0);
      drive("R1", 1, 1, 0, 2'd0, 0, 16'h0101, 4'd0);
      drive("R1", 1, 1, 0, 2'd0, 0, 16'h0102, 4'd0);
      drive("R1", 1, 1, 0, 2'd0, 0, 16'h0100, 4'd0);
      // R3 reserved filter bits ignored
      set_cfg(20'h70101, 8'h01, 4'd0, 4'd0);
      drive("R3", 1, 1, 0, 2'd0, 0, 16'h0101, 4'd0);
      drive("R3", 1, 1, 0, 2'd0, 0, 16'h1101, 4'd0);
      // R2 port mask built from slots 0x10 and 0x11
      set_cfg(20'h80000 | (20'd1 << slot2port(16)) | (20'd1 << slot2port(17)), 8'h07, 4'd0, 4'd0);
      drive("R2", 1, 1, 0, 2'd0, 0, 16'h0000, 4'(slot2port(16)));
      drive("R2", 1, 1, 0, 2'd1, 0, 16'hbeef, 4'(slot2port(17)));
      drive("R2", 1, 1, 0, 2'd0, 0, 16'h0005, 4'd1);
      drive("R2", 1, 1, 0, 2'd2, 0, 16'h0005, 4'd4);
      // R4 class mask, upper bits ignored
      set_cfg(20'h00101, 8'hFA, 4'd0, 4'd0);
      for (int c = 0; c < 4; c++) drive("R4", 1, 1, 0, 2'(c), 0, 16'h0101, 4'd0);
      // R5 / R6 / R7 sweep of format, direction code, direction, class, group
      for (int fm = 0; fm < 2; fm++)
         for (int d = 0; d < 4; d++)
            for (int ob = 0; ob < 2; ob++)
               for (int c = 0; c < 3; c++)
                  for (int r = 0; r < 2; r++) begin
                     set_cfg(20'h00101, 8'(1 << c), 4'(d), 4'(fm));
                     drive((c == 2 && ob == 0) ? "R7" : (fm == 0 ? "R5" : "R6"),
                           1, 1, ob[0], 2'(c), r[0], 16'h0101, 4'd0);
                  end
      // R7 explicit: compact code 3 takes only group-A inbound completions
      set_cfg(20'h00101, 8'h04, 4'd3, 4'd0);
      drive("R7", 1, 1, 0, 2'd2, 1, 16'h0101, 4'd0);
      drive("R7", 1, 1, 0, 2'd2, 0, 16'h0101, 4'd0);
      // R8 outbound needs exactly one class bit
      set_cfg(20'h00101, 8'h03, 4'd1, 4'd0);
      drive("R8", 1, 1, 1, 2'd0, 0, 16'h0101, 4'd0);
      set_cfg(20'h00101, 8'h00, 4'd2, 4'd0);
      drive("R8", 1, 1, 1, 2'd0, 0, 16'h0101, 4'd0);
      set_cfg(20'h00101, 8'h07, 4'd0, 4'd0);
      drive("R8", 1, 1, 0, 2'd1, 0, 16'h0101, 4'd0);
      // R9 reserved codes
      set_cfg(20'h00101, 8'h01, 4'd4, 4'd0);
      drive("R9", 1, 1, 0, 2'd0, 0, 16'h0101, 4'd0);
      set_cfg(20'h00101, 8'h01, 4'd0, 4'd2);
      drive("R9", 1, 1, 0, 2'd0, 0, 16'h0101, 4'd0);
      set_cfg(20'h00101, 8'h01, 4'd0, 4'd1);
      drive("R9", 1, 1, 0, 2'd0, 0, 16'h0101, 4'd0);
      // R10 disable, no valid, back-to-back strobes
      set_cfg(20'h00101, 8'h01, 4'd0, 4'd0);
      drive("R10", 0, 1, 0, 2'd0, 0, 16'h0101, 4'd0);
      drive("R10", 1, 0, 0, 2'd0, 0, 16'h0101, 4'd0);
      drive("R10", 1, 1, 0, 2'd0, 0, 16'h0101, 4'd0);
      drive("R10", 1, 1, 0, 2'd0, 0, 16'h0101, 4'd0);
      drive("R10", 1, 0, 0, 2'd0, 0, 16'h0101, 4'd0);
      repeat (4) @(negedge clk);
      done = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end
endmodule